// File: doc/BRIEF.md
# Bus-Recovering Software Watchdog

This block is a software watchdog for a small processor subsystem. Once software sets its enable bit, a counter measures clocks against a programmable period. Software stops the count from reaching the period by arming a service register with one key byte and then firing it with a second key byte. If the period runs out, the block does one of two things, chosen by a control bit. It can raise a reset request for the system reset sequencer. It can also raise an interrupt that stays pending until it is acknowledged.

In interrupt mode the block can also recover from a hung bus. The hung-bus case is an expiry that comes while the earlier interrupt is still pending and a bus cycle has not ended. If forced acknowledge is enabled, the block then drives a transfer-acknowledge to end that cycle. It holds this acknowledge until the next bus cycle starts. A sticky status flag records the event, so the interrupt handler can find the access that never completed.

The register port has no back-pressure. Every write is accepted in the cycle `wr_en` is high. Reads are combinational from `rd_addr`. All other pins are plain level or pulse controls. Register map: CTRL at address 0, SVC at address 1, STAT at address 2. CTRL fields are bit 7 enable, bit 6 action, bit 5 forced acknowledge enable, bit 4 prescale, bits 3:2 period select; bits 1:0 read as 0. STAT fields are bit 0 forced acknowledge flag and bit 1 watchdog reset flag.

Top module: `swdt_top`

## Requirements
- R1: While `rst_n` is low, and right after it rises, CTRL reads 0x00, STAT bit 0 reads 0, `irq`, `rst_req` and `force_ta` are low, and the counter does not run.
- R2: With CTRL[4]=0, an expiry occurs 2^(9+2*sel) clocks after the enabling write or the last reload, where sel is CTRL[3:2]. A changed sel is compared against the running count immediately.
- R3: A write of 0xAA to SVC (address 1) while the sequence is armed reloads the count, so the next expiry comes one full period after that write. It also disarms the sequence.
- R4: A write of 0x55 to SVC arms the sequence. Other SVC writes and any reads leave it armed. SVC bit 0 reads the armed state.
- R5: A write of 0xAA to SVC while not armed does not reload the count.
- R6: With CTRL[6]=0 (reset action), an expiry raises `rst_req`, which stays high until `rst_n` goes low. The expiry also sets STAT bit 1.
- R7: With CTRL[6]=1 (interrupt action), an expiry raises `irq`, which stays high until `irq_ack`. An expiry while `irq` is still pending, with CTRL[5]=1 and `bus_active` high, raises `force_ta` and sets STAT bit 0.
- R8: `force_ta` stays high until a `bus_start` pulse, and drops on the clock edge that samples it.
- R9: Writing STAT with bit 0 set clears the forced acknowledge flag.
- R10: CTRL[7] (enable) is write-once. A later CTRL write with bit 7 clear leaves the watchdog enabled and counting.
- R11: STAT bit 1 survives `rst_n`. Only `por_n` clears it.
- R12: With CTRL[4]=1 the period is multiplied by 2^PRE_EXP (default 15).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| por_n | input | 1 | Active-low power-on reset; clears the reset flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational |
| bus_start | input | 1 | Pulse: a new bus cycle starts |
| bus_active | input | 1 | A bus cycle is in progress and not terminated |
| irq | output | 1 | Watchdog interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| rst_req | output | 1 | System reset request |
| force_ta | output | 1 | Forced transfer-acknowledge |
| flag_ta | output | 1 | Sticky forced acknowledge flag |
| flag_rst | output | 1 | Sticky watchdog reset flag |

## Verification
Some properties are checked on every cycle: the enable bit never falls, the reset request and the forced acknowledge hold until their release events, and a pending interrupt waits for its acknowledge. The cycle-level rules are also checked each cycle: an arming write leaves the sequence armed, a fire write zeroes the count, and a flag clear takes effect. Other behaviour can only be shown by the bench's scenarios. These are the exact expiry cycle for each period and prescale choice, and whether unrelated writes and unarmed fire writes really leave the schedule unchanged. The second-expiry path to a forced acknowledge, and the reset flag surviving a system reset, also need full scenarios.

// File: rtl/swdt_pkg.sv
package swdt_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_SVC  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  typedef struct packed {
    logic       en;
    logic       irq_mode;
    logic       ta_en;
    logic       pre;
    logic [1:0] sel;
    logic [1:0] rsvd;
  } ctrl_t;
endpackage

// File: rtl/swdt_regs.sv
module swdt_regs
  import swdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [1:0]  rd_addr,
  output logic [7:0]  rd_data,
  input  logic        ta_set,
  input  logic        rst_set,
  output ctrl_t       ctrl,
  output logic        svc_ok,
  output logic        ta_flag,
  output logic        rst_flag
);
  ctrl_t ctrl_q;
  ctrl_t wr_ctrl;
  logic  armed;
  logic  svc_wr, ctrl_wr, stat_wr;

  assign wr_ctrl = ctrl_t'(wr_data);
  assign svc_wr  = wr_en && (wr_addr == A_SVC);
  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign stat_wr = wr_en && (wr_addr == A_STAT);
  assign svc_ok  = svc_wr && (wr_data == KEY_FIRE) && armed;
  assign ctrl    = ctrl_q;

  // Control register; enable may only go from 0 to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q.en       <= ctrl_q.en | wr_ctrl.en;
      ctrl_q.irq_mode <= wr_ctrl.irq_mode;
      ctrl_q.ta_en    <= wr_ctrl.ta_en;
      ctrl_q.pre      <= wr_ctrl.pre;
      ctrl_q.sel      <= wr_ctrl.sel;
      ctrl_q.rsvd     <= '0;
    end
  end

  // Two-key service sequence state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              armed <= 1'b0;
    else if (svc_ok)                         armed <= 1'b0;
    else if (svc_wr && wr_data == KEY_ARM)   armed <= 1'b1;
  end

  // Forced-acknowledge flag, write one to clear, set wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ta_flag <= 1'b0;
    else if (ta_set)                 ta_flag <= 1'b1;
    else if (stat_wr && wr_data[0])  ta_flag <= 1'b0;
  end

  // Watchdog-reset flag lives in the power-on domain only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       rst_flag <= 1'b0;
    else if (rst_set) rst_flag <= 1'b1;
  end

  always_comb begin
    unique case (rd_addr)
      A_CTRL:  rd_data = ctrl_q;
      A_SVC:   rd_data = {7'd0, armed};
      A_STAT:  rd_data = {6'd0, rst_flag, ta_flag};
      default: rd_data = 8'd0;
    endcase
  end

  a_r10_en_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.en |=> ctrl_q.en);
  a_r4_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_wr && wr_data == KEY_ARM) |=> armed);
  a_r3_fire_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    svc_ok |=> !armed);
  a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wr_data[0] && !ta_set) |=> !ta_flag);
endmodule

// File: rtl/swdt_timer.sv
module swdt_timer #(
  parameter int BASE_EXP = 9,
  parameter int STEP_EXP = 2,
  parameter int PRE_EXP  = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       pre,
  input  logic [1:0] sel,
  input  logic       svc_ok,
  output logic       expire
);
  localparam int SEL_N = 4;
  localparam int LIM_N = 2 * SEL_N;
  localparam int CNT_W = BASE_EXP + STEP_EXP * (SEL_N - 1) + PRE_EXP;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim [LIM_N];

  // Terminal count for every (prescale, select) pair
  for (genvar p = 0; p < 2; p++) begin : g_pre
    for (genvar s = 0; s < SEL_N; s++) begin : g_sel
      localparam int EXP = BASE_EXP + STEP_EXP * s + p * PRE_EXP;
      assign lim[p*SEL_N+s] = CNT_W'((64'd1 << EXP) - 64'd1);
    end
  end

  assign expire = en && (cnt >= lim[{pre, sel}]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (svc_ok || expire) cnt <= '0;
    else if (en)               cnt <= cnt + 1'b1;
  end

  a_r3_reload_zero: assert property (@(posedge clk) disable iff (!rst_n)
    svc_ok |=> (cnt == '0));
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !svc_ok) |=> $stable(cnt));
endmodule

// File: rtl/swdt_action.sv
module swdt_action (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic irq_mode,
  input  logic ta_en,
  input  logic bus_active,
  input  logic bus_start,
  input  logic irq_ack,
  output logic irq,
  output logic rst_req,
  output logic force_ta,
  output logic ta_set,
  output logic rst_set
);
  // A repeat expiry with the interrupt still pending means a hung bus
  assign ta_set  = expire && irq_mode && irq && ta_en && bus_active && !bus_start;
  assign rst_set = expire && !irq_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    irq <= 1'b0;
    else if (expire && irq_mode)   irq <= 1'b1;
    else if (irq_ack)              irq <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rst_req <= 1'b0;
    else if (rst_set) rst_req <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         force_ta <= 1'b0;
    else if (bus_start) force_ta <= 1'b0;
    else if (ta_set)    force_ta <= 1'b1;
  end

  a_r8_ta_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (force_ta && !bus_start) |=> force_ta);
  a_r8_ta_release: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> !force_ta);
  a_r6_rst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
  a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);
  a_r7_ta_after_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_ta) |-> $past(irq));
endmodule

// File: rtl/swdt_top.sv
module swdt_top
  import swdt_pkg::*;
#(
  parameter int BASE_EXP = 9,
  parameter int STEP_EXP = 2,
  parameter int PRE_EXP  = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       bus_start,
  input  logic       bus_active,
  output logic       irq,
  input  logic       irq_ack,
  output logic       rst_req,
  output logic       force_ta,
  output logic       flag_ta,
  output logic       flag_rst
);
  ctrl_t ctrl;
  logic  svc_ok, expire, ta_set, rst_set;

  swdt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .ta_set(ta_set), .rst_set(rst_set),
    .ctrl(ctrl), .svc_ok(svc_ok),
    .ta_flag(flag_ta), .rst_flag(flag_rst)
  );

  swdt_timer #(.BASE_EXP(BASE_EXP), .STEP_EXP(STEP_EXP), .PRE_EXP(PRE_EXP)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .pre(ctrl.pre), .sel(ctrl.sel),
    .svc_ok(svc_ok), .expire(expire)
  );

  swdt_action u_action (
    .clk(clk), .rst_n(rst_n), .expire(expire),
    .irq_mode(ctrl.irq_mode), .ta_en(ctrl.ta_en),
    .bus_active(bus_active), .bus_start(bus_start), .irq_ack(irq_ack),
    .irq(irq), .rst_req(rst_req), .force_ta(force_ta),
    .ta_set(ta_set), .rst_set(rst_set)
  );

  a_r7_flag_with_ta: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_ta) |-> flag_ta);
  a_r6_flag_with_rst: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(rst_req) |-> flag_rst);
endmodule

// File: tb/test_swdt_top.sv
module test_swdt_top;
  localparam int PRE_EXP = 4;
  localparam int K_IRQ = 0, K_RST = 1, K_TA = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0, por_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic bus_start = 1'b0, bus_active = 1'b0, irq_ack = 1'b0;
  logic irq, rst_req, force_ta, flag_ta, flag_rst;

  int cyc = 0;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  int last_wr;

  typedef struct { int kind; int at; string req; } evt_t;
  evt_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  swdt_top #(.PRE_EXP(PRE_EXP)) i_swdt_top (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .bus_start(bus_start), .bus_active(bus_active),
    .irq(irq), .irq_ack(irq_ack), .rst_req(rst_req), .force_ta(force_ta),
    .flag_ta(flag_ta), .flag_rst(flag_rst)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(input int kind, input int at, input string req);
    evt_t e;
    e.kind = kind; e.at = at; e.req = req;
    sb.push_back(e);
  endtask

  // Monitor: every rising event output is matched against the scoreboard
  logic p_irq = 1'b0, p_rst = 1'b0, p_ta = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq && !p_irq)     match(K_IRQ);
      if (rst_req && !p_rst) match(K_RST);
      if (force_ta && !p_ta) match(K_TA);
    end
    p_irq = irq; p_rst = rst_req; p_ta = force_ta;
  end

  task automatic match(input int kind);
    evt_t e;
    if (sb.size() == 0) begin
      checks++; errors++;
      $display("FAIL R2 unexpected event kind=%0d actual=%0d expected=none", kind, cyc);
    end else begin
      e = sb.pop_front();
      chk({e.req, " kind"}, kind, e.kind);
      chk({e.req, " cycle"}, cyc, e.at);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    last_wr = cyc;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic ack_irq();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R7 irq released by ack", int'(irq), 0);
  endtask

  task automatic service(output int at);
    wr(2'd1, 8'h55);
    wr(2'd1, 8'hAA);
    at = last_wr;
  endtask

  initial begin
    int v, s2, x, r, u, w, e0;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", int'(irq), 0);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk("R1 ctrl reset", v, 8'h00);
    rd(2'd2, v); chk("R1 stat reset", v, 8'h00);
    chk("R1 outputs idle", {irq, rst_req, force_ta}, 0);
    repeat (600) @(negedge clk);
    chk("R1 no expiry while disabled", int'(irq), 0);

    // Interrupt mode, forced acknowledge enabled, sel 0 -> 512 clocks
    wr(2'd0, 8'hE0); e0 = last_wr;
    push(K_IRQ, e0 + 512, "R2 first expiry");
    wait_until(e0 + 515);
    ack_irq();

    // Service with clutter between the keys (R3, R4)
    wr(2'd1, 8'h55);
    wr(2'd1, 8'h33);
    rd(2'd2, v);
    rd(2'd1, v); chk("R4 armed after junk write", v, 1);
    wr(2'd1, 8'h55);
    wr(2'd1, 8'hAA); s2 = last_wr;
    rd(2'd1, v); chk("R3 disarmed after fire", v, 0);
    push(K_IRQ, s2 + 512, "R3 expiry after service");
    wait_until(s2 + 515);
    ack_irq();

    // Unarmed fire key must not reload (R5)
    wr(2'd1, 8'hAA);
    rd(2'd1, v); chk("R5 still unarmed", v, 0);
    x = s2 + 1024;
    push(K_IRQ, x, "R5 schedule unchanged");
    wait_until(x + 2);

    // Second expiry with irq pending and a hung bus (R7, R8, R9)
    bus_active = 1'b1;
    push(K_TA, x + 512, "R7 forced acknowledge");
    wait_until(x + 514);
    rd(2'd2, v); chk("R7 ta flag set", v & 1, 1);
    chk("R7 flag pin", int'(flag_ta), 1);
    chk("R7 irq still pending", int'(irq), 1);
    repeat (5) @(negedge clk);
    chk("R8 ta held", int'(force_ta), 1);
    bus_start = 1'b1;
    @(negedge clk); bus_start = 1'b0; bus_active = 1'b0;
    chk("R8 ta released by bus start", int'(force_ta), 0);
    rd(2'd2, v); chk("R8 flag sticky", v & 1, 1);
    wr(2'd2, 8'h01);
    rd(2'd2, v); chk("R9 flag cleared", v & 1, 0);
    ack_irq();
    service(r);

    // Enable is write-once (R10)
    wr(2'd0, 8'h60);
    rd(2'd0, v); chk("R10 enable kept", v, 8'hE0);
    push(K_IRQ, r + 512, "R10 still counting");
    wait_until(r + 515);
    ack_irq();

    // Period select change after servicing (R2)
    service(u);
    wr(2'd0, 8'hE4);
    push(K_IRQ, u + 2048, "R2 sel=1 period");
    wait_until(u + 2051);
    ack_irq();

    // Prescale (R12): 512 * 2^PRE_EXP
    service(w);
    wr(2'd0, 8'hF0);
    push(K_IRQ, w + (512 << PRE_EXP), "R12 prescaled period");
    wait_until(w + (512 << PRE_EXP) + 3);
    ack_irq();

    // Reset action (R6, R11)
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 irq cleared by reset", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk("R1 ctrl cleared by reset", v, 0);
    wr(2'd0, 8'h80); e0 = last_wr;
    push(K_RST, e0 + 512, "R6 reset request");
    wait_until(e0 + 514);
    rd(2'd2, v); chk("R6 reset flag", v, 8'h02);
    chk("R6 irq quiet", int'(irq), 0);
    repeat (5) @(negedge clk);
    chk("R6 reset request held", int'(rst_req), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R6 request dropped by reset", int'(rst_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd2, v); chk("R11 reset flag survives", v, 8'h02);
    chk("R11 flag pin", int'(flag_rst), 1);
    por_n = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    rd(2'd2, v); chk("R11 cleared by power-on", v, 8'h00);

    chk("R2 scoreboard drained", sb.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=finished", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule